// File: doc/BRIEF.md
# Windowed Slow-Tick Watchdog

This peripheral guards a processor against hangs and runaway code. A 12-bit down-counter advances on a 256 Hz tick enable, so 256 ticks make one second. Software must service it with a keyed restart command before the counter runs out. A restart counts only inside a window. A restart that arrives while the counter is still above the window threshold is treated as a fault, just as expiry is. A fault can request a reset, which may be limited to the processor core, and it can raise an interrupt.

The configuration word can be written only once after reset, so errant code cannot change it later. The same word can switch the block off entirely, or freeze counting while the processor is idle or halted for debug. Software reaches the block through a small register bus with three locations: command, configuration and fault status.

Top module: `slowtick_watchdog`

## Requirements
- R1: After reset the configuration register (address 1) reads 0x3FFF2FFF. Fault status (address 2) reads 0, address 3 reads 0, and the reset request, core-only flag and interrupt outputs are all low.
- R2: Only the first write to the configuration register after reset is stored, in bits 29:0; bits 31:30 read as 0. Every later write leaves the read-back value unchanged.
- R3: While running, the counter drops by one on each cycle with the tick enable high. The tick that takes it from 1 to 0 is an expiry fault, which sets status bit 0. At 0 the counter stays at 0.
- R4: A write to the command register (address 0) with 0xA5 in bits 31:24 and bit 0 set is a restart. A restart reloads the counter from configuration bits 11:0. A command write with any other key has no effect.
- R5: A restart taken while the counter is greater than the window threshold (configuration bits 27:16) is an early-restart fault, which sets status bit 1. The counter is still reloaded.
- R6: If configuration bit 13 is set when a fault occurs, the reset request goes high and stays high until reset. If bit 14 is also set at that moment, the core-only flag goes high as well.
- R7: If configuration bit 12 is set when a fault occurs, the interrupt goes high. A read of the status register returns both fault bits, then clears them and drops the interrupt. A fault in the same cycle as the read takes priority over the clear.
- R8: With configuration bit 15 set, the counter does not move, restarts are ignored and no fault can occur.
- R9: With configuration bit 29 set, ticks have no effect while the idle input is high. With bit 28 set, ticks have no effect while the debug input is high.
- R10: The accepted configuration write loads the counter with its new bits 11:0. A restart or configuration load in the same cycle as a tick takes priority over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 256 Hz counting rate |
| cpu_idle | input | 1 | Processor is idle |
| cpu_debug | input | 1 | Processor is halted for debug |
| bus_req | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | 0 command, 1 configuration, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wd_reset_req | output | 1 | Sticky reset request |
| wd_cpu_only | output | 1 | The reset request targets only the processor core |
| wd_irq | output | 1 | Fault interrupt |

## Verification
Directed runs cover several cases. A full default count tells an off-by-one expiry apart from a correct one. A second configuration write checks the write-once lock, and a wrong key is compared against the right key. A restart right after configuration tests the window, and further runs cover the off switch and the idle halt. Random runs then pick random reload values, thresholds, fault routing and halt options. Against these settings they drive random ticks, idle and debug levels, good and bad restarts, status reads and configuration writes. A cycle-accurate bench model is compared with the outputs every cycle and with every read. This separates errors in tick gating, in restart priority over ticks, and in fault priority over the clear-on-read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 30;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Configuration word layout, bit 29 down to bit 0.
  typedef struct packed {
    logic             idle_halt;
    logic             dbg_halt;
    logic [CNT_W-1:0] window;
    logic             wd_off;
    logic             core_only;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] reload;
  } cfg_t;
endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = 30'h3FFF2FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q,
  output logic             accept
);
  cfg_t cfg_d;
  logic lock_q, lock_d;

  always_comb begin
    accept = wr_req & ~lock_q;
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (accept) begin
      cfg_d  = cfg_t'(wr_data);
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= cfg_t'(RST_VAL);
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q));
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_d;
  logic         at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = ~load & run & (cnt_q == ONE);
    cnt_d   = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && !at_zero)
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_fault_unit.sv
module wdt_fault_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic early_evt,
  input  logic irq_en,
  input  logic rst_en,
  input  logic core_only,
  input  logic stat_rd,
  output logic expire_q,
  output logic early_q,
  output logic irq_q,
  output logic rst_req_q,
  output logic core_q
);
  logic fault;
  logic expire_d, early_d, irq_d, rst_req_d, core_d;

  always_comb begin
    fault     = expire_evt | early_evt;
    expire_d  = expire_evt | (expire_q & ~stat_rd);
    early_d   = early_evt  | (early_q  & ~stat_rd);
    irq_d     = (fault & irq_en) | (irq_q & ~stat_rd);
    rst_req_d = rst_req_q | (fault & rst_en);
    core_d    = core_q | (fault & rst_en & core_only);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expire_q  <= 1'b0;
      early_q   <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      core_q    <= 1'b0;
    end else begin
      expire_q  <= expire_d;
      early_q   <= early_d;
      irq_q     <= irq_d;
      rst_req_q <= rst_req_d;
      core_q    <= core_d;
    end
  end

  assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);
  assert_core_needs_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_q |-> rst_req_q);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !expire_evt && !early_evt) |=> (!irq_q && !expire_q && !early_q));
endmodule

// File: rtl/slowtick_watchdog.sv
module slowtick_watchdog
  import wdt_pkg::*;
#(
  parameter logic [7:0]       CMD_KEY = 8'hA5,
  parameter logic [CFG_W-1:0] CFG_RST = 30'h3FFF2FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cpu_idle,
  input  logic              cpu_debug,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_reset_req,
  output logic              wd_cpu_only,
  output logic              wd_irq
);
  localparam int KEY_LSB = DATA_W - 8;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  reg_sel_e         sel;
  cfg_t             cfg;
  logic             cfg_wr, cfg_accept;
  logic             restart, early, run, load, expire, stat_rd;
  logic [CNT_W-1:0] cnt, load_val;
  logic             st_expire, st_early;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    cfg_wr   = bus_req & bus_wr & (sel == REG_CFG);
    stat_rd  = bus_req & ~bus_wr & (sel == REG_STAT);
    restart  = bus_req & bus_wr & (sel == REG_CMD) & ~cfg.wd_off &
               (bus_wdata[DATA_W-1:KEY_LSB] == CMD_KEY) & bus_wdata[0];
    early    = restart & (cnt > cfg.window);
    run      = tick_en & ~cfg.wd_off & ~(cfg.idle_halt & cpu_idle) &
               ~(cfg.dbg_halt & cpu_debug);
    load     = restart | cfg_accept;
    load_val = cfg_accept ? bus_wdata[CNT_W-1:0] : cfg.reload;
  end

  wdt_cfg_lock #(.RST_VAL(CFG_RST)) i_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_req  (cfg_wr),
    .wr_data (bus_wdata[CFG_W-1:0]),
    .cfg_q   (cfg),
    .accept  (cfg_accept)
  );

  wdt_down_counter #(.W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .load     (load),
    .load_val (load_val),
    .cnt_q    (cnt),
    .expire   (expire)
  );

  wdt_fault_unit i_fault (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .expire_evt (expire),
    .early_evt  (early),
    .irq_en     (cfg.irq_en),
    .rst_en     (cfg.rst_en),
    .core_only  (cfg.core_only),
    .stat_rd    (stat_rd),
    .expire_q   (st_expire),
    .early_q    (st_early),
    .irq_q      (wd_irq),
    .rst_req_q  (wd_reset_req),
    .core_q     (wd_cpu_only)
  );

  always_comb begin
    unique case (sel)
      REG_CFG:  bus_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
      REG_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, st_early, st_expire};
      default:  bus_rdata = '0;
    endcase
  end

  assert_early_flag_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (restart && cnt > cfg.window) |=> st_early);
  assert_expire_flag_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !load && cnt == CNT_W'(1)) |=> st_expire);
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.wd_off && !cfg_accept) |=> $stable(cnt));
endmodule

// File: tb/test_slowtick_watchdog.sv
module test_slowtick_watchdog;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, cpu_idle, cpu_debug, bus_req, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wd_reset_req, wd_cpu_only, wd_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model of the requirements.
  logic [29:0] m_cfg;
  logic        m_lock, m_uf, m_er, m_irq, m_rst, m_core;
  logic [11:0] m_cnt;
  logic [31:0] rd_last;

  always #(CLK_P/2) clk = ~clk;

  slowtick_watchdog i_slowtick_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_idle(cpu_idle),
    .cpu_debug(cpu_debug), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_reset_req(wd_reset_req), .wd_cpu_only(wd_cpu_only), .wd_irq(wd_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd1:    return {2'b00, m_cfg};
      2'd2:    return {30'd0, m_er, m_uf};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cyc(input bit tk, input bit idl, input bit dbg, input bit rq, input bit wr,
                     input logic [1:0] ad, input logic [31:0] wd, input string tag);
    bit run, rs, cw, uf, er, sr, ev;
    @(negedge clk);
    tick_en = tk; cpu_idle = idl; cpu_debug = dbg;
    bus_req = rq; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
    #1;
    if (rq && !wr) begin
      rd_last = bus_rdata;
      check(bus_rdata == exp_read(ad), tag, bus_rdata, exp_read(ad));
    end
    @(posedge clk);
    run = tk && !m_cfg[15] && !(m_cfg[29] && idl) && !(m_cfg[28] && dbg);
    rs  = rq && wr && ad == 2'd0 && wd[31:24] == 8'hA5 && wd[0] && !m_cfg[15];
    cw  = rq && wr && ad == 2'd1 && !m_lock;
    sr  = rq && !wr && ad == 2'd2;
    uf  = !rs && !cw && run && m_cnt == 12'd1;
    er  = rs && (m_cnt > m_cfg[27:16]);
    ev  = uf || er;
    m_uf   = uf || (m_uf && !sr);
    m_er   = er || (m_er && !sr);
    m_irq  = (ev && m_cfg[12]) || (m_irq && !sr);
    m_rst  = m_rst || (ev && m_cfg[13]);
    m_core = m_core || (ev && m_cfg[13] && m_cfg[14]);
    if (cw)             m_cnt = wd[11:0];
    else if (rs)        m_cnt = m_cfg[11:0];
    else if (run && m_cnt != 0) m_cnt = m_cnt - 12'd1;
    if (cw) begin m_cfg = wd[29:0]; m_lock = 1'b1; end
    #1;
    check(wd_irq == m_irq, "R7 irq", {31'd0, wd_irq}, {31'd0, m_irq});
    check(wd_reset_req == m_rst, "R6 reset", {31'd0, wd_reset_req}, {31'd0, m_rst});
    check(wd_cpu_only == m_core, "R6 core", {31'd0, wd_cpu_only}, {31'd0, m_core});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 2'd0, 32'd0, "idle");
  endtask
  task automatic ticks(input int n, input bit idl, input bit dbg);
    for (int i = 0; i < n; i++) cyc(1, idl, dbg, 0, 0, 2'd0, 32'd0, "tick");
  endtask
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 1, 1, a, d, "write");
  endtask
  task automatic rd_reg(input logic [1:0] a, input string tag);
    cyc(0, 0, 0, 1, 0, a, 32'd0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick_en = 0; cpu_idle = 0; cpu_debug = 0;
    bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_cfg = 30'h3FFF2FFF; m_lock = 0; m_cnt = 12'hFFF;
    m_uf = 0; m_er = 0; m_irq = 0; m_rst = 0; m_core = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    do_reset();
    rd_reg(2'd1, "R1 cfg reset");
    check(rd_last == 32'h3FFF2FFF, "R1 cfg value", rd_last, 32'h3FFF2FFF);
    rd_reg(2'd2, "R1 status reset");
    rd_reg(2'd3, "R1 spare");
    // R3 / R6: default configuration runs out after 4095 ticks
    ticks(4094, 0, 0);
    check(wd_reset_req == 0, "R3 before expiry", {31'd0, wd_reset_req}, 32'd0);
    ticks(1, 0, 0);
    check(wd_reset_req == 1, "R3 at expiry", {31'd0, wd_reset_req}, 32'd1);
    check(wd_cpu_only == 0, "R6 full reset", {31'd0, wd_cpu_only}, 32'd0);
    rd_reg(2'd2, "R3 status expire");
    check(rd_last == 32'd1, "R3 expire bit", rd_last, 32'd1);

    // R2, R10, R7
    do_reset();
    wr_reg(2'd1, 32'h000A_100A);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, "R2 locked");
    check(rd_last == 32'h000A_100A, "R2 first write kept", rd_last, 32'h000A_100A);
    ticks(9, 0, 0);
    check(wd_irq == 0, "R10 reload 10 early", {31'd0, wd_irq}, 32'd0);
    ticks(1, 0, 0);
    check(wd_irq == 1, "R10 reload 10 expiry", {31'd0, wd_irq}, 32'd1);
    rd_reg(2'd2, "R7 status read");
    check(rd_last == 32'd1 && wd_irq == 0, "R7 clear on read", {wd_irq, rd_last[30:0]}, 32'd1);
    rd_reg(2'd2, "R7 status cleared");

    // R4: wrong key ignored, right key reloads
    do_reset();
    wr_reg(2'd1, 32'h0008_1008);
    ticks(5, 0, 0);
    wr_reg(2'd0, 32'h5A00_0001);
    ticks(3, 0, 0);
    check(wd_irq == 1, "R4 wrong key ignored", {31'd0, wd_irq}, 32'd1);
    do_reset();
    wr_reg(2'd1, 32'h0008_1008);
    ticks(5, 0, 0);
    wr_reg(2'd0, 32'hA500_0001);
    ticks(7, 0, 0);
    check(wd_irq == 0, "R4 restart reloads", {31'd0, wd_irq}, 32'd0);
    ticks(1, 0, 0);
    check(wd_irq == 1, "R4 expiry after reload", {31'd0, wd_irq}, 32'd1);

    // R5 / R6: early restart, core-only reset
    do_reset();
    wr_reg(2'd1, 32'h0005_6014);
    ticks(2, 0, 0);
    wr_reg(2'd0, 32'hA500_0001);
    check(wd_reset_req == 1 && wd_cpu_only == 1, "R5 early restart reset",
          {30'd0, wd_reset_req, wd_cpu_only}, 32'd3);
    rd_reg(2'd2, "R5 status early");
    check(rd_last == 32'd2, "R5 early bit", rd_last, 32'd2);

    // R8: switched off
    do_reset();
    wr_reg(2'd1, 32'h0000_B005);
    ticks(50, 0, 0);
    wr_reg(2'd0, 32'hA500_0001);
    check(wd_irq == 0 && wd_reset_req == 0, "R8 off quiet", {30'd0, wd_irq, wd_reset_req}, 32'd0);
    rd_reg(2'd2, "R8 status");
    check(rd_last == 32'd0, "R8 no fault", rd_last, 32'd0);

    // R9: idle halt
    do_reset();
    wr_reg(2'd1, 32'h2004_1004);
    ticks(20, 1, 0);
    check(wd_irq == 0, "R9 idle frozen", {31'd0, wd_irq}, 32'd0);
    ticks(4, 0, 1);
    check(wd_irq == 1, "R9 debug counts", {31'd0, wd_irq}, 32'd1);

    // Random runs
    for (int it = 0; it < 30; it++) begin
      logic [11:0] rl, wn;
      logic [31:0] cfgw;
      do_reset();
      rl = 12'(2 + $urandom_range(0, 20));
      wn = 12'($urandom_range(0, int'(rl)));
      cfgw = {2'b00, $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, wn,
              $urandom_range(0,7) == 0, $urandom_range(0,1) == 1,
              $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, rl};
      wr_reg(2'd1, cfgw);
      for (int c = 0; c < 150; c++) begin
        int op;
        bit tk, idl, dbg;
        tk  = $urandom_range(0,1) == 1;
        idl = $urandom_range(0,3) == 0;
        dbg = $urandom_range(0,3) == 0;
        op  = $urandom_range(0,99);
        if (op < 10)
          cyc(tk, idl, dbg, 1, 1, 2'd0,
              ($urandom_range(0,4) == 0) ? 32'h3C00_0001 : 32'hA500_0001, "R4 restart");
        else if (op < 20)
          cyc(tk, idl, dbg, 1, 0, 2'd2, 32'd0, "R7 status");
        else if (op < 23)
          cyc(tk, idl, dbg, 1, 1, 2'd1, $urandom, "R2 rewrite");
        else
          cyc(tk, idl, dbg, 0, 0, 2'd0, 32'd0, "R3 run");
      end
      rd_reg(2'd1, "R2 random cfg");
    end
    finish_run();
  end
endmodule